// File: doc/BRIEF.md
# Maskable latched interrupt aggregator

This block gathers up to twenty level-sensitive interrupt lines from board peripherals and combines them into one interrupt request for a parent processor. It holds three registers. The first is a raw-level copy of the inputs. The second is an enable mask. The third is a sticky pending register. A pending bit is set when its input is high while its mask bit is on, and it stays set after the input falls.

Host software uses a small synchronous register port. It reads all three registers and writes the mask. It also overwrites the pending register directly, so one write can acknowledge some bits and force others. Both writable registers pass every write through a fixed pattern of writable bits. Bit positions 8 and 12 can never hold a one. The parent interrupt is registered and follows the OR of the pending bits that are enabled.

Top module: `irq_latch_agg`

## Requirements
- R1: The raw-level register (address 0) holds the value of `irq_in` sampled at the previous rising clock edge, whatever the mask holds.
- R2: At each rising edge, a pending bit is set when its `irq_in` bit is 1 and the mask bit held before that edge is 1. An input that is high while its mask bit is 0 leaves its pending bit at 0.
- R3: When an input falls, its pending bit does not clear. Only a write to the pending register clears pending bits.
- R4: Every write to the mask (address 1) or pending (address 2) register is ANDed with 0xFEEFF. Bits 8 and 12 always read 0.
- R5: A write to the pending register replaces its whole contents with the filtered data, so one write can set some bits and clear others.
- R6: `irq_out` is 1 exactly when (pending AND mask) is nonzero. It updates at the same edge as the registers that cause the change, so it is visible one clock after the input or the write.
- R7: A mask write re-evaluates `irq_out`. Unmasking a bit that is already pending raises it, and masking the only enabled pending bit lowers it.
- R8: Reads decode as follows: address 0 is raw level, 1 is mask, 2 is pending, and 3 reads 0. Data bits above the interrupt count read 0. Writes to addresses 0 and 3 change no register.
- R9: Reset (`rst_n` low, asynchronous) clears the raw, mask and pending registers and holds `irq_out` low.
- R10: A pending write and a hardware set in the same cycle are combined. The bit whose input is high and enabled ends set, whatever value was written for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Level-sensitive peripheral interrupt inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from address |
| irq_out | output | 1 | Interrupt request to the parent processor |

## Verification
On every cycle, assertions check several invariants. The raw register must trail the inputs by one cycle. No pending bit may appear unless its mask bit was on, and none may vanish without a pending write. A pending write must yield the filtered data OR the enabled inputs. Neither writable register may hold a bit outside the writable pattern, and `irq_out` must match the enabled pending OR. Only the bench scenarios can show some behaviours: the address decode, the fact that writes to read-only addresses are ignored, a mask write raising or lowering the request against a chosen pending state, and a reset that arrives mid-run.

// File: rtl/irq_latch_agg.sv
module irq_latch_agg #(
  parameter int NUM_IRQ = 20,
  parameter int DW = 32,
  parameter logic [NUM_IRQ-1:0] WR_MASK = 20'hFEEFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               irq_out
);
  localparam logic [1:0] A_RAW  = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_PEND = 2'd2;

  logic [NUM_IRQ-1:0] raw_q, mask_q, pend_q, mask_d, pend_d, wr_val;
  logic mask_wr, pend_wr;

  assign mask_wr = reg_we && (reg_addr == A_MASK);
  assign pend_wr = reg_we && (reg_addr == A_PEND);
  assign wr_val  = reg_wdata[NUM_IRQ-1:0] & WR_MASK;
  assign mask_d  = mask_wr ? wr_val : mask_q;
  assign pend_d  = (pend_wr ? wr_val : pend_q) | (irq_in & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      mask_q  <= '0;
      pend_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      raw_q   <= irq_in;
      mask_q  <= mask_d;
      pend_q  <= pend_d;
      irq_out <= |(pend_d & mask_d);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RAW:   reg_rdata[NUM_IRQ-1:0] = raw_q;
      A_MASK:  reg_rdata[NUM_IRQ-1:0] = mask_q;
      A_PEND:  reg_rdata[NUM_IRQ-1:0] = pend_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_RAW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> raw_q == $past(irq_in)); // R1
  AST_NO_MASKED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(pend_wr)) |-> ((pend_q & ~$past(pend_q) & ~$past(mask_q)) == '0)); // R2
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(pend_wr)) |-> (($past(pend_q) & ~pend_q) == '0)); // R3
  AST_WR_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & ~WR_MASK) == '0) && ((pend_q & ~WR_MASK) == '0)); // R4
  AST_PEND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pend_wr)) |->
      pend_q == (($past(reg_wdata[NUM_IRQ-1:0]) & WR_MASK) | ($past(irq_in) & $past(mask_q)))); // R10
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |(pend_q & mask_q)); // R6
endmodule

// File: tb/sim_irq_latch_agg.sv
`timescale 1ns/1ps
module sim_irq_latch_agg;
  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [19:0] irq_in = '0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_out;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_latch_agg u0 (.clk, .rst_n, .irq_in, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .irq_out);

  typedef struct packed {
    logic [19:0] irq; logic we; logic [1:0] addr; logic [31:0] wdata;
    logic [19:0] pend; logic irqo;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{20'h00001, 1'b0, 2'd0, 32'h0,       20'h00000, 1'b0}, // R2 masked
    '{20'h00000, 1'b1, 2'd1, 32'hFFFFFFFF, 20'h00000, 1'b0}, // R4 mask all
    '{20'h00003, 1'b0, 2'd0, 32'h0,       20'h00003, 1'b1}, // R2 R6 latch
    '{20'h00000, 1'b0, 2'd0, 32'h0,       20'h00003, 1'b1}, // R3 sticky
    '{20'h00000, 1'b1, 2'd2, 32'h00104,   20'h00004, 1'b1}, // R4 R5 replace
    '{20'h00000, 1'b1, 2'd1, 32'h00003,   20'h00004, 1'b0}, // R7 lower
    '{20'h00000, 1'b1, 2'd1, 32'h00004,   20'h00004, 1'b1}, // R7 raise
    '{20'h00004, 1'b1, 2'd2, 32'h0,       20'h00004, 1'b1}, // R10 hw wins
    '{20'h00002, 1'b1, 2'd2, 32'h0,       20'h00000, 1'b0}  // R2 R5 clear
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [19:0] irq, input logic we, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    irq_in = irq; reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    reg_we = 0; reg_addr = a; #0.5;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12;
    chk("R9 irq_out in reset", {31'b0, irq_out}, 32'h0);
    @(negedge clk); rst_n = 1;
    rd(2'd0, 0, "R9 raw after reset");
    rd(2'd1, 0, "R9 mask after reset");
    rd(2'd2, 0, "R9 pend after reset");

    foreach (VEC[i]) begin
      step(VEC[i].irq, VEC[i].we, VEC[i].addr, VEC[i].wdata);
      chk($sformatf("R6 irq_out vec %0d", i), {31'b0, irq_out}, {31'b0, VEC[i].irqo});
      rd(2'd2, {12'b0, VEC[i].pend}, $sformatf("R2 R3 R5 pend vec %0d", i));
      if (i == 1) rd(2'd1, 32'h000FEEFF, "R4 mask filtered");
      if (i == 2) rd(2'd0, 32'h00003, "R1 raw level");
    end
    rd(2'd0, 32'h00002, "R1 raw ignores mask");

    step(20'h0, 1'b1, 2'd0, 32'hFFFFFFFF);
    rd(2'd1, 32'h00004, "R8 write addr0 ignored mask");
    rd(2'd2, 32'h0, "R8 write addr0 ignored pend");
    step(20'h0, 1'b1, 2'd3, 32'hFFFFFFFF);
    rd(2'd3, 32'h0, "R8 addr3 reads zero");
    rd(2'd1, 32'h00004, "R8 write addr3 ignored");

    step(20'h0, 1'b1, 2'd2, 32'hFFFFFFFF);
    rd(2'd2, 32'h000FEEFF, "R4 pend filtered upper zero");
    chk("R6 irq_out after pend write", {31'b0, irq_out}, 32'h1);

    @(negedge clk); rst_n = 0; #1;
    chk("R9 mid-run reset irq", {31'b0, irq_out}, 32'h0);
    rd(2'd2, 0, "R9 mid-run reset pend");
    rd(2'd1, 0, "R9 mid-run reset mask");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule